// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address and a set of granted access rights. It does this by reading up to three page-table entries from memory, one per level. A caller hands it one request at a time. Each request carries the virtual address, a mode code (kernel, user or physical) and the access it needs (any mix of read, write and execute). The walker finishes with a one-cycle `done` pulse. Along with the pulse it gives a success flag, a fault code, the physical address and the granted rights.

Two cases finish without touching memory: physical mode, and the kernel-only direct-mapped segment. Every other translated address goes through the three-level walk. The walk starts at the page-table base input. Each entry it reads gives the base of the next table, and the last entry gives the page frame.

Requests enter on a valid/ready pair. `req_ready` is high only while the walker is idle. A request held valid while the walker is busy simply waits; it is not dropped. Table reads leave on a valid/ready request channel, and `mem_req_valid` with its address is held until `mem_req_ready` accepts it. The matching read data comes back on `mem_rsp_valid`, with no back-pressure, and only one read is outstanding at a time. The result outputs have no back-pressure either. They are held until the walker finishes the next request.

Top module: `ptw3_walker`

## Requirements
- R1: With mode code 2 (physical), the result is success with `res_paddr` equal to the virtual address, `res_prot` = 7, fault code 0 and no table reads.
- R2: In a translated mode (code 0 = kernel, 1 = user), bits 63:43 of the address must all be equal. If they are not, the result is an access-violation fault (code 1) with address and rights both zero and no table reads.
- R3: An address with bit 63 set and bits 42:41 equal to 2'b10 is in the direct-mapped segment and causes no table reads. In kernel mode the result is success with rights 7 and a physical address made of bits 39:0 plus bit 40 moved to bit 43. In user mode the result is fault code 1 with address and rights both zero.
- R4: A walk reads 8-byte entries at table base + index*8. The indices are address bits 42:33, then 32:23, then 22:13. The first base is `ptbr`. Each later base is the upper 32 bits of the entry just read, shifted left by 13. A walk makes exactly as many reads as the levels it reaches.
- R5: At levels 1 and 2, an entry with bit 0 (valid) clear ends the walk with translation-not-valid (code 2). An entry that is valid but has bit 8 (kernel read enable) clear ends the walk with code 1. In both cases the address and rights are zero.
- R6: At level 3, an entry with bit 0 clear gives code 2 with rights zero. The address is the frame (upper 32 bits shifted left by 13) with the 13-bit page offset ORed in. This frame-plus-offset address is reported for every level-3 outcome.
- R7: At level 3, read (1) and execute (4) are granted when entry bit 8+mode is set, and write (2) is granted when entry bit 12+mode is set. If the needed access is nonzero and has no overlap with the granted rights, the result is code 1 and the granted rights are reported.
- R8: Otherwise the granted rights are cleared where entry bits 1, 2 and 3 (fault on read, write, execute) are set. If the needed access is nonzero and no longer overlaps, the fault code is 5 when execute is needed, else 4 when write is needed, else 3. In all other cases the result is success with fault code 0. A zero needed access always succeeds once level 3 is valid.
- R9: `req_ready` is high only while idle. `done` is high for exactly one cycle per request. The result outputs change only in the cycle where `done` is high.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle, request accepted on this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_mode | input | 2 | 0 kernel, 1 user, 2 physical |
| req_need | input | 3 | Needed access: read 1, write 2, execute 4 |
| ptbr | input | 64 | Level-1 table base, sampled at the start of a walk |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | One-cycle completion pulse |
| res_ok | output | 1 | Translation succeeded |
| res_fault | output | 3 | 0 none, 1 access violation, 2 not valid, 3 fault-read, 4 fault-write, 5 fault-execute |
| res_paddr | output | 64 | Physical address |
| res_prot | output | 3 | Granted rights |

## Verification
The bench targets several corner cases:
- Direct-mapped addresses with bit 40 set. A design that drops or misplaces the relocated bit returns a wrong address.
- Addresses with a broken sign extension. A design that skips the check starts a table walk, and the bench's read count catches that.
- Leaf entries that set several fault-on bits while the needed access mixes rights. A wrong fault priority, or a mask applied before the access-violation test, returns the wrong code.
- Random stall patterns on the read channel. These expose a request that drops or changes its address before it is accepted.
- User-mode leaves that only grant rights through bits 9 and 13. These catch enables that ignore the mode.

// File: rtl/ptw3_pkg.sv
package ptw3_pkg;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_USER = 2'd1,
    MODE_PHYS = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_ACV  = 3'd1,
    FLT_TNV  = 3'd2,
    FLT_FOR  = 3'd3,
    FLT_FOW  = 3'd4,
    FLT_FOE  = 3'd5
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_MREQ,
    ST_MWAIT,
    ST_FIN
  } state_e;

  localparam logic [2:0] PROT_ALL = 3'b111;

  // entry bit positions
  localparam int PTE_V   = 0;
  localparam int PTE_FO  = 1;   // three fault-on bits, read/write/exec
  localparam int PTE_KRE = 8;   // read enables, one per mode
  localparam int PTE_KWE = 12;  // write enables, one per mode

endpackage

// File: rtl/ptw3_precheck.sv
module ptw3_precheck
  import ptw3_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int IMPL_BITS = 43,
  parameter int SEG_LO    = 41,
  parameter int KSEG_W    = 40,
  parameter int RELOC_BIT = 43
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic [1:0]      mode,
  output logic            resolved,
  output logic [2:0]      fault,
  output logic [VA_W-1:0] paddr,
  output logic [2:0]      prot
);
  localparam int TOP_W = VA_W - IMPL_BITS;

  logic [TOP_W-1:0] top_bits;
  logic             sign_ok;
  logic             in_kseg;

  assign top_bits = vaddr[VA_W-1:IMPL_BITS];
  assign sign_ok  = (&top_bits) | ~(|top_bits);
  assign in_kseg  = vaddr[VA_W-1] && (vaddr[SEG_LO+1:SEG_LO] == 2'b10);

  always_comb begin
    resolved = 1'b0;
    fault    = FLT_NONE;
    paddr    = '0;
    prot     = '0;
    if (mode == MODE_PHYS) begin
      resolved = 1'b1;
      paddr    = vaddr;
      prot     = PROT_ALL;
    end else if (!sign_ok) begin
      resolved = 1'b1;
      fault    = FLT_ACV;
    end else if (in_kseg) begin
      resolved = 1'b1;
      if (mode != MODE_KERN) begin
        fault = FLT_ACV;
      end else begin
        paddr            = {{(VA_W-KSEG_W){1'b0}}, vaddr[KSEG_W-1:0]};
        paddr[RELOC_BIT] = vaddr[KSEG_W];
        prot             = PROT_ALL;
      end
    end
  end
endmodule

// File: rtl/ptw3_index.sv
module ptw3_index #(
  parameter int VA_W      = 64,
  parameter int PAGE_BITS = 13,
  parameter int IDX_W     = 10,
  parameter int LEVELS    = 3,
  parameter int LVL_W     = 2
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  input  logic [VA_W-1:0]  base,
  output logic [VA_W-1:0]  entry_addr
);
  localparam int USED_HI = PAGE_BITS + IDX_W*LEVELS;

  logic [IDX_W-1:0] idx_by_lvl [LEVELS];
  logic [IDX_W-1:0] idx_sel;
  logic             unused_va;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    localparam int SH = PAGE_BITS + IDX_W*(LEVELS-1-g);
    assign idx_by_lvl[g] = vaddr[SH +: IDX_W];
  end

  always_comb begin
    idx_sel = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (level == LVL_W'(i)) idx_sel = idx_by_lvl[i];
    end
  end

  assign entry_addr = base + {{(VA_W-IDX_W-3){1'b0}}, idx_sel, 3'b000};
  assign unused_va  = ^{vaddr[VA_W-1:USED_HI], vaddr[PAGE_BITS-1:0]};
endmodule

// File: rtl/ptw3_leaf.sv
module ptw3_leaf
  import ptw3_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PTE_W     = 64,
  parameter int PAGE_BITS = 13
) (
  input  logic [PTE_W-1:0]     pte,
  input  logic [1:0]           mode,
  input  logic [2:0]           need,
  input  logic [PAGE_BITS-1:0] offset,
  output logic                 ok,
  output logic [2:0]           fault,
  output logic [VA_W-1:0]      paddr,
  output logic [2:0]           prot
);
  logic [3:0]      rd_grp, wr_grp;
  logic [2:0]      granted, masked;
  logic [VA_W-1:0] frame;
  logic            unused_pte;

  assign rd_grp  = pte[PTE_KRE +: 4];
  assign wr_grp  = pte[PTE_KWE +: 4];
  assign granted = {rd_grp[mode], wr_grp[mode], rd_grp[mode]};
  assign masked  = granted & ~pte[PTE_FO +: 3];
  assign frame   = {{(VA_W-32){1'b0}}, pte[PTE_W-1:PTE_W-32]} << PAGE_BITS;
  assign paddr   = frame | {{(VA_W-PAGE_BITS){1'b0}}, offset};

  always_comb begin
    ok    = 1'b0;
    fault = FLT_NONE;
    prot  = '0;
    if (!pte[PTE_V]) begin
      fault = FLT_TNV;
    end else if ((need != 3'b0) && ((granted & need) == 3'b0)) begin
      fault = FLT_ACV;
      prot  = granted;
    end else begin
      prot = masked;
      if ((need != 3'b0) && ((masked & need) == 3'b0)) begin
        if (need[2])      fault = FLT_FOE;
        else if (need[1]) fault = FLT_FOW;
        else              fault = FLT_FOR;
      end else begin
        ok = 1'b1;
      end
    end
  end

  assign unused_pte = ^{pte[PTE_W-33:PTE_KWE+4], pte[PTE_KRE-1:PTE_FO+3]};
endmodule

// File: rtl/ptw3_walker.sv
module ptw3_walker
  import ptw3_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PTE_W     = 64,
  parameter int PAGE_BITS = 13,
  parameter int IMPL_BITS = 43,
  parameter int IDX_W     = 10,
  parameter int LEVELS    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_mode,
  input  logic [2:0]       req_need,
  input  logic [VA_W-1:0]  ptbr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [VA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic             res_ok,
  output logic [2:0]       res_fault,
  output logic [VA_W-1:0]  res_paddr,
  output logic [2:0]       res_prot
);
  localparam int LVL_W = $clog2(LEVELS);

  state_e           state;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       mode_q;
  logic [2:0]       need_q;
  logic [LVL_W-1:0] lvl_q;

  logic             pre_res;
  logic [2:0]       pre_fault, leaf_fault, pre_prot, leaf_prot;
  logic [VA_W-1:0]  pre_paddr, leaf_paddr, rsp_frame, idx_base, entry_addr;
  logic [LVL_W-1:0] idx_level;
  logic             leaf_ok, last_lvl;

  ptw3_precheck #(.VA_W(VA_W), .IMPL_BITS(IMPL_BITS)) u_pre (
    .vaddr(va_q), .mode(mode_q), .resolved(pre_res),
    .fault(pre_fault), .paddr(pre_paddr), .prot(pre_prot));

  assign rsp_frame = {{(VA_W-32){1'b0}}, mem_rsp_data[PTE_W-1:PTE_W-32]} << PAGE_BITS;
  assign idx_base  = (state == ST_PRE) ? ptbr : rsp_frame;
  assign idx_level = (state == ST_PRE) ? '0 : lvl_q + LVL_W'(1);
  assign last_lvl  = (lvl_q == LVL_W'(LEVELS-1));

  ptw3_index #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W),
               .LEVELS(LEVELS), .LVL_W(LVL_W)) u_idx (
    .vaddr(va_q), .level(idx_level), .base(idx_base), .entry_addr(entry_addr));

  ptw3_leaf #(.VA_W(VA_W), .PTE_W(PTE_W), .PAGE_BITS(PAGE_BITS)) u_leaf (
    .pte(mem_rsp_data), .mode(mode_q), .need(need_q),
    .offset(va_q[PAGE_BITS-1:0]), .ok(leaf_ok), .fault(leaf_fault),
    .paddr(leaf_paddr), .prot(leaf_prot));

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_MREQ);
  assign done          = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      va_q         <= '0;
      mode_q       <= '0;
      need_q       <= '0;
      lvl_q        <= '0;
      mem_req_addr <= '0;
      res_ok       <= 1'b0;
      res_fault    <= FLT_NONE;
      res_paddr    <= '0;
      res_prot     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          mode_q <= req_mode;
          need_q <= req_need;
          state  <= ST_PRE;
        end
        ST_PRE: begin
          if (pre_res) begin
            res_ok    <= (pre_fault == FLT_NONE);
            res_fault <= pre_fault;
            res_paddr <= pre_paddr;
            res_prot  <= pre_prot;
            state     <= ST_FIN;
          end else begin
            mem_req_addr <= entry_addr;
            lvl_q        <= '0;
            state        <= ST_MREQ;
          end
        end
        ST_MREQ: if (mem_req_ready) state <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          if (last_lvl) begin
            res_ok    <= leaf_ok;
            res_fault <= leaf_fault;
            res_paddr <= leaf_paddr;
            res_prot  <= leaf_prot;
            state     <= ST_FIN;
          end else if (!mem_rsp_data[PTE_V] || !mem_rsp_data[PTE_KRE]) begin
            res_ok    <= 1'b0;
            res_fault <= mem_rsp_data[PTE_V] ? FLT_ACV : FLT_TNV;
            res_paddr <= '0;
            res_prot  <= '0;
            state     <= ST_FIN;
          end else begin
            mem_req_addr <= entry_addr;
            lvl_q        <= lvl_q + LVL_W'(1);
            state        <= ST_MREQ;
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw3_walker_chk.sv
module ptw3_walker_chk #(
  parameter int VA_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            done,
  input logic            res_ok,
  input logic [2:0]      res_fault,
  input logic [VA_W-1:0] res_paddr,
  input logic [2:0]      res_prot,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [VA_W-1:0] mem_req_addr
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || done) |-> !req_ready);

  assert_result_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({res_ok, res_fault, res_paddr, res_prot}));

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_ok_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_ok == (res_fault == 3'd0)));
endmodule

bind ptw3_walker ptw3_walker_chk #(.VA_W(VA_W)) chk_i (.*);

// File: tb/ptw3_walker_tb_top.sv
`timescale 1ns/1ps
module ptw3_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_mode = '0;
  logic [2:0]  req_need = '0;
  logic [63:0] ptbr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done, res_ok;
  logic [2:0]  res_fault, res_prot;
  logic [63:0] res_paddr;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  logic [63:0] mem [logic [63:0]];

  always #2 clk = ~clk;

  ptw3_walker dut_i (.*);

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [63:0] rd_mem(logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  // reference model written from the requirements
  function automatic void model(input logic [63:0] va, input logic [1:0] md,
      input logic [2:0] nd, input logic [63:0] pt,
      output logic e_ok, output logic [2:0] e_flt, output logic [63:0] e_pa,
      output logic [2:0] e_prot, output int e_rd, output string e_tag);
    logic [63:0] tbl, ent;
    logic [2:0]  g;
    e_ok = 0; e_flt = 3'd1; e_pa = 0; e_prot = 0; e_rd = 0; e_tag = "R2";
    if (md == 2'd2) begin
      e_ok = 1; e_flt = 0; e_pa = va; e_prot = 7; e_tag = "R1"; return;
    end
    if (va[63:43] != {21{va[63]}}) return;
    if (va[63] && va[42:41] == 2'b10) begin
      e_tag = "R3";
      if (md == 2'd0) begin
        e_ok = 1; e_flt = 0; e_prot = 7; e_pa = {20'h0, va[40], 3'b000, va[39:0]};
      end
      return;
    end
    tbl = pt;
    for (int lv = 0; lv < 3; lv++) begin
      int sh;
      sh  = 13 + 10 * (2 - lv);
      ent = rd_mem(tbl + (((va >> sh) & 64'h3FF) << 3));
      e_rd++;
      if (lv < 2) begin
        if (!ent[0]) begin e_flt = 2; e_tag = "R5"; return; end
        if (!ent[8]) begin e_flt = 1; e_tag = "R5"; return; end
        tbl = {32'h0, ent[63:32]} << 13;
      end else begin
        e_pa = ({32'h0, ent[63:32]} << 13) | (va & 64'h1FFF);
        if (!ent[0]) begin e_flt = 2; e_tag = "R6"; return; end
        g[0] = ent[8 + md]; g[2] = ent[8 + md]; g[1] = ent[12 + md];
        e_prot = g;
        if (nd != 0 && (g & nd) == 0) begin e_flt = 1; e_tag = "R7"; return; end
        g = g & ~ent[3:1];
        e_prot = g; e_tag = "R8";
        if (nd != 0 && (g & nd) == 0) e_flt = nd[2] ? 3'd5 : (nd[1] ? 3'd4 : 3'd3);
        else begin e_ok = 1; e_flt = 0; end
      end
    end
  endfunction

  task automatic set_path(logic [63:0] va, logic [63:0] pt,
                          logic [63:0] p1, logic [63:0] p2, logic [63:0] p3);
    mem.delete();
    mem[pt + {51'h0, va[42:33], 3'b000}] = p1;
    mem[({32'h0, p1[63:32]} << 13) + {51'h0, va[32:23], 3'b000}] = p2;
    mem[({32'h0, p2[63:32]} << 13) + {51'h0, va[22:13], 3'b000}] = p3;
  endtask

  // memory responder with random stalls and latency
  initial begin : mem_model
    logic        pend, hold;
    logic [63:0] a_l, hold_addr;
    int          dly;
    pend = 0; hold = 0; a_l = 0; hold_addr = 0; dly = 0;
    forever begin
      @(posedge clk);
      hold = 0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        pend = 1; a_l = mem_req_addr; dly = $urandom % 3; rd_cnt++;
      end else if (rst_n && mem_req_valid) begin
        hold = 1; hold_addr = mem_req_addr;
      end
      @(negedge clk);
      if (hold) begin
        check("R10", "stall valid", {63'h0, mem_req_valid}, 64'h1);
        check("R10", "stall addr", mem_req_addr, hold_addr);
      end
      mem_rsp_valid = 0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = rd_mem(a_l); pend = 0;
        end else dly--;
      end
      mem_req_ready = ($urandom % 4) != 0;
    end
  end

  task automatic run_req(logic [63:0] va, logic [1:0] md, logic [2:0] nd, logic [63:0] pt);
    logic        e_ok;
    logic [2:0]  e_flt, e_prot;
    logic [63:0] e_pa;
    int          e_rd, n;
    string       tg;
    logic [70:0] snap;
    @(negedge clk);
    check("R9", "ready idle", {63'h0, req_ready}, 64'h1);
    rd_cnt = 0;
    req_valid = 1; req_vaddr = va; req_mode = md; req_need = nd; ptbr = pt;
    @(negedge clk);
    req_valid = 0;
    check("R9", "ready busy", {63'h0, req_ready}, 64'h0);
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    if (!done) begin
      errors++;
      $display("FAIL R9 no done actual=0 expected=1");
      return;
    end
    model(va, md, nd, pt, e_ok, e_flt, e_pa, e_prot, e_rd, tg);
    check(tg, "ok", {63'h0, res_ok}, {63'h0, e_ok});
    check(tg, "fault", {61'h0, res_fault}, {61'h0, e_flt});
    check(tg, "paddr", res_paddr, e_pa);
    check(tg, "prot", {61'h0, res_prot}, {61'h0, e_prot});
    check("R4", "reads", 64'(rd_cnt), 64'(e_rd));
    snap = {res_ok, res_fault, res_paddr, res_prot};
    @(negedge clk);
    check("R9", "done pulse", {63'h0, done}, 64'h0);
    check("R9", "held", 64'({res_ok, res_fault, res_paddr, res_prot} == snap), 64'h1);
  endtask

  function automatic logic [63:0] rand_pte();
    logic [63:0] p;
    p = 0;
    p[63:32] = $urandom;
    p[0]  = ($urandom % 8) != 0;
    p[1]  = ($urandom % 4) == 0;
    p[2]  = ($urandom % 4) == 0;
    p[3]  = ($urandom % 4) == 0;
    p[8]  = ($urandom % 4) != 0;
    p[9]  = ($urandom % 4) != 0;
    p[12] = ($urandom % 4) != 0;
    p[13] = ($urandom % 4) != 0;
    return p;
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    summary();
  end

  localparam logic [63:0] VA_T = 64'h0000_0123_4567_89AB;
  localparam logic [63:0] PT0  = 64'h0000_0000_0010_0000;
  localparam logic [63:0] P12  = {32'h0000_0200, 32'h0000_0101};
  localparam logic [63:0] P23  = {32'h0000_0300, 32'h0000_0101};

  initial begin : main
    logic [63:0] va;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    check("R9", "reset done", {63'h0, done}, 64'h0);
    check("R10", "reset memreq", {63'h0, mem_req_valid}, 64'h0);
    rst_n = 1;
    @(negedge clk);
    check("R9", "reset ready", {63'h0, req_ready}, 64'h1);

    // R1 physical bypass
    run_req(64'hFFFF_0000_1234_5678, 2'd2, 3'd2, PT0);
    // R2 broken sign extension
    run_req(64'h0000_1000_0000_0000, 2'd0, 3'd1, PT0);
    // R3 direct segment, kernel with bit 40 set, then user
    run_req(64'hFFFF_FD12_3456_789A, 2'd0, 3'd4, PT0);
    check("R3", "reloc literal", res_paddr, 64'h0000_0812_3456_789A);
    run_req(64'hFFFF_FD12_3456_789A, 2'd1, 3'd1, PT0);
    // R5 level 1 and level 2 faults
    set_path(VA_T, PT0, 64'h0, P23, 64'h0);
    run_req(VA_T, 2'd0, 3'd1, PT0);
    set_path(VA_T, PT0, {32'h200, 32'h1}, P23, 64'h0);
    run_req(VA_T, 2'd0, 3'd1, PT0);
    set_path(VA_T, PT0, P12, 64'h0, 64'h0);
    run_req(VA_T, 2'd0, 3'd1, PT0);
    // R6 leaf not valid
    set_path(VA_T, PT0, P12, P23, {32'h4444, 32'h0000_1100});
    run_req(VA_T, 2'd0, 3'd1, PT0);
    // R7 user read via bit 9, kernel write without enable
    set_path(VA_T, PT0, P12, P23, {32'h4444, 32'h0000_0201});
    run_req(VA_T, 2'd1, 3'd1, PT0);
    set_path(VA_T, PT0, P12, P23, {32'h4444, 32'h0000_0101});
    run_req(VA_T, 2'd0, 3'd2, PT0);
    // R8 fault-on priority and zero need
    set_path(VA_T, PT0, P12, P23, {32'h4444, 32'h0000_1109});
    run_req(VA_T, 2'd0, 3'd4, PT0);
    set_path(VA_T, PT0, P12, P23, {32'h4444, 32'h0000_110F});
    run_req(VA_T, 2'd0, 3'd6, PT0);
    set_path(VA_T, PT0, P12, P23, {32'h4444, 32'h0000_1103});
    run_req(VA_T, 2'd0, 3'd1, PT0);
    set_path(VA_T, PT0, P12, P23, {32'h4444, 32'h0000_110F});
    run_req(VA_T, 2'd0, 3'd0, PT0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int          cat;
      logic [1:0]  md;
      logic [2:0]  nd;
      logic [63:0] pt;
      cat = $urandom % 10;
      md  = 2'($urandom % 2);
      case ($urandom % 4)
        0: nd = 3'd0; 1: nd = 3'd1; 2: nd = 3'd2; default: nd = 3'd4;
      endcase
      if (($urandom % 5) == 0) nd = 3'($urandom % 8);
      va = {$urandom, $urandom};
      va[63:43] = {21{va[63]}};
      pt = {32'h0, $urandom} << 13;
      if (cat == 0) md = 2'd2;
      else if (cat == 1) va[50] = ~va[50];
      else if (cat == 2) begin va[63:43] = '1; va[42:41] = 2'b10; end
      set_path(va, pt, rand_pte(), rand_pte(), rand_pte());
      run_req(va, md, nd, pt);
    end
    summary();
  end
endmodule